// File: doc/BRIEF.md
# Cell-Bus Receive Master Poller

This block is the receiving master on a shared cell bus that connects several PHY devices. It steps through the PHYs by placing each address on a 5-bit address output. One cycle later it samples the cell-available response. A PHY answers only when its address is on the bus. The block picks a PHY only when that PHY offers a cell and the PHY's local cell FIFO is not almost full. It then pulls the active-low enable down and captures one whole cell, either byte-wide or word-wide.

Every captured beat goes to the selected PHY's FIFO write port. The block checks odd parity on each beat and flags a mismatch on that PHY's error line. On the beat that completes the cell, it pulses that PHY's cell-count increment. The start-of-cell marker sets the beat count of a cell, so a marker that arrives in the middle of a cell restarts the count.

The FIFO storage and any processing of cell headers sit outside this block.

Top module: `cellRxPoller`

## Requirements
- R1: While reset is held, and at release, the enable output is high (inactive), the address output is 0, and no FIFO write enable, increment or parity-error line is active.
- R2: Each polled address is held for two cycles. Cell-available is sampled at the end of the second cycle. A PHY is selected only if cell-available was high at that point. The enable falls in the next cycle, and the address does not change while the enable is low.
- R3: A PHY whose almost-full input is high when its cell-available is sampled is not selected. Polling moves on, and that PHY is served once its almost-full input clears.
- R4: The poll address advances round-robin over 0 to NUM_PHY-1 and wraps to 0. After a cell is served, polling resumes at the PHY after the one that was served. With PHYs 0, 1 and 3 each holding two cells, service alternates cyclically among them.
- R5: With DATA_W = 8, a cell is 53 beats, and the enable stays low for exactly 53 cycles when no extra start-of-cell arrives. The enable stays high for at least one cycle between two cells.
- R6: With DATA_W = 16, a cell is 27 beats, and each beat's bus bits 15:8 appear unchanged in FIFO data bits 15:8.
- R7: Every beat sampled while the enable is low appears one cycle later on FIFO data slice p (bits p*DATA_W upward) of the selected PHY p. It appears with a one-cycle write-enable pulse for PHY p only, and at most one write enable is active per cycle.
- R8: The increment pulse for PHY p is a single cycle and coincides with the write enable of that cell's last beat. The enable returns high in that same cycle.
- R9: Parity is odd, meaning the data bits plus the parity bit must contain an odd number of ones. A beat that fails this raises the selected PHY's parity-error line for one cycle, in the cycle of that beat's write enable. Beats with correct parity raise no error.
- R10: A start-of-cell on a beat of an ongoing cell makes that beat the first of a new cell. With DATA_W = 8 and a marker on beat index 10, the enable stays low for 63 cycles and one increment is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock for all registers |
| rstN | input | 1 | Active-low synchronous reset |
| phyAddr | output | 5 | Poll / select address |
| phyEnbN | output | 1 | Active-low transfer enable |
| phyClav | input | 1 | Cell-available response of the addressed PHY |
| phySoc | input | 1 | Start-of-cell marker on the current beat |
| phyData | input | DATA_W | Cell data beat |
| phyParity | input | 1 | Odd parity bit for phyData |
| fifoAlmostFull | input | NUM_PHY | Per-PHY FIFO cannot take another cell |
| fifoWrData | output | NUM_PHY*DATA_W | Per-PHY FIFO write data |
| fifoWrEn | output | NUM_PHY | Per-PHY FIFO write enable |
| cellIncr | output | NUM_PHY | Per-PHY cell-count increment pulse |
| parityErr | output | NUM_PHY | Per-PHY parity error pulse |

## Verification
The checks on the almost-full gate assume the almost-full flag of the PHY under selection does not change between the sample and the first beat. The bench changes almost-full only while that PHY has no pending cell, or well clear of a selection. The checks also assume that the addressed PHY answers cell-available only for its own address and keeps driving beats for as long as the enable is low. The bench PHY model computes cell-available from its pending-cell count for the current address, and it drives a new beat on every falling clock edge while the enable is low.

// File: rtl/cellRxPkg.sv
package cellRxPkg;
  localparam int ADDR_W = 5;

  typedef struct packed {
    logic              capture;
    logic              lastBeat;
    logic [ADDR_W-1:0] phySel;
  } rxStrobe_t;

  typedef enum logic [1:0] {
    ST_POLL  = 2'd0,
    ST_CHECK = 2'd1,
    ST_XFER  = 2'd2
  } rxState_t;
endpackage

// File: rtl/cellRxCtrl.sv
module cellRxCtrl
  import cellRxPkg::*;
#(
  parameter int NUM_PHY  = 4,
  parameter int CELL_LEN = 53
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               phyClav,
  input  logic               phySoc,
  input  logic [NUM_PHY-1:0] fifoAlmostFull,
  output logic [ADDR_W-1:0]  phyAddr,
  output logic               phyEnbN,
  output rxStrobe_t          strobe
);
  localparam int PW = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1;
  localparam int CW = $clog2(CELL_LEN + 1);

  rxState_t        state;
  logic [PW-1:0]   cand;
  logic [PW-1:0]   candNext;
  logic [CW-1:0]   beatCnt;
  logic [CW-1:0]   beatCntNext;
  logic            isLast;
  logic            canTake;

  // round-robin successor of the current candidate
  always_comb begin
    if (cand == PW'(NUM_PHY - 1)) candNext = '0;
    else                          candNext = cand + PW'(1);
  end

  assign beatCntNext = phySoc ? CW'(1) : beatCnt + CW'(1);
  assign isLast      = (state == ST_XFER) && (beatCntNext == CW'(CELL_LEN));
  assign canTake     = phyClav && !fifoAlmostFull[cand];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_POLL;
      cand    <= '0;
      phyEnbN <= 1'b1;
      beatCnt <= '0;
    end else begin
      unique case (state)
        ST_POLL: state <= ST_CHECK;
        ST_CHECK: begin
          if (canTake) begin
            state   <= ST_XFER;
            phyEnbN <= 1'b0;
            beatCnt <= '0;
          end else begin
            cand  <= candNext;
            state <= ST_POLL;
          end
        end
        ST_XFER: begin
          beatCnt <= beatCntNext;
          if (isLast) begin
            phyEnbN <= 1'b1;
            cand    <= candNext;
            state   <= ST_POLL;
          end
        end
        default: state <= ST_POLL;
      endcase
    end
  end

  assign phyAddr         = ADDR_W'(cand);
  assign strobe.capture  = (state == ST_XFER);
  assign strobe.lastBeat = isLast;
  assign strobe.phySel   = ADDR_W'(cand);
endmodule

// File: rtl/cellRxDatapath.sv
module cellRxDatapath
  import cellRxPkg::*;
#(
  parameter int NUM_PHY = 4,
  parameter int DATA_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  rxStrobe_t                 strobe,
  input  logic [DATA_W-1:0]         phyData,
  input  logic                      phyParity,
  output logic [NUM_PHY*DATA_W-1:0] fifoWrData,
  output logic [NUM_PHY-1:0]        fifoWrEn,
  output logic [NUM_PHY-1:0]        cellIncr,
  output logic [NUM_PHY-1:0]        parityErr
);
  logic [DATA_W-1:0] beatReg;
  logic              badParity;

  // odd parity: data plus parity bit must hold an odd count of ones
  assign badParity = ~(^{phyData, phyParity});

  always_ff @(posedge clk) begin
    if (!rstN)              beatReg <= '0;
    else if (strobe.capture) beatReg <= phyData;
  end

  for (genvar g = 0; g < NUM_PHY; g++) begin : gPhy
    logic hit;
    assign hit = strobe.capture && (strobe.phySel == ADDR_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        fifoWrEn[g]  <= 1'b0;
        cellIncr[g]  <= 1'b0;
        parityErr[g] <= 1'b0;
      end else begin
        fifoWrEn[g]  <= hit;
        cellIncr[g]  <= hit && strobe.lastBeat;
        parityErr[g] <= hit && badParity;
      end
    end

    assign fifoWrData[g*DATA_W +: DATA_W] = beatReg;
  end
endmodule

// File: rtl/cellRxPoller.sv
module cellRxPoller
  import cellRxPkg::*;
#(
  parameter int NUM_PHY = 4,
  parameter int DATA_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  output logic [4:0]                phyAddr,
  output logic                      phyEnbN,
  input  logic                      phyClav,
  input  logic                      phySoc,
  input  logic [DATA_W-1:0]         phyData,
  input  logic                      phyParity,
  input  logic [NUM_PHY-1:0]        fifoAlmostFull,
  output logic [NUM_PHY*DATA_W-1:0] fifoWrData,
  output logic [NUM_PHY-1:0]        fifoWrEn,
  output logic [NUM_PHY-1:0]        cellIncr,
  output logic [NUM_PHY-1:0]        parityErr
);
  // beats per cell: 53 bytes, or 27 words with the final word half used
  localparam int CELL_LEN = (DATA_W == 16) ? 27 : 53;

  rxStrobe_t strobe;

  cellRxCtrl #(.NUM_PHY(NUM_PHY), .CELL_LEN(CELL_LEN)) ctrl_i (
    .clk(clk), .rstN(rstN), .phyClav(phyClav), .phySoc(phySoc),
    .fifoAlmostFull(fifoAlmostFull), .phyAddr(phyAddr),
    .phyEnbN(phyEnbN), .strobe(strobe)
  );

  cellRxDatapath #(.NUM_PHY(NUM_PHY), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .phyData(phyData),
    .phyParity(phyParity), .fifoWrData(fifoWrData),
    .fifoWrEn(fifoWrEn), .cellIncr(cellIncr), .parityErr(parityErr)
  );
endmodule

// File: rtl/cellRxPollerChk.sv
module cellRxPollerChk #(
  parameter int NUM_PHY = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [4:0]         phyAddr,
  input logic               phyEnbN,
  input logic               phyClav,
  input logic [NUM_PHY-1:0] fifoAlmostFull,
  input logic [NUM_PHY-1:0] fifoWrEn,
  input logic [NUM_PHY-1:0] cellIncr,
  input logic [NUM_PHY-1:0] parityErr
);
  localparam int PW = (NUM_PHY > 1) ? $clog2(NUM_PHY) : 1;
  logic afSel;
  assign afSel = fifoAlmostFull[phyAddr[PW-1:0]];

  assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    phyAddr < 5'(NUM_PHY));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !phyEnbN |-> $stable(phyAddr));

  assert_select_clav_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phyEnbN) |-> $past(phyClav));

  assert_no_full_select_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phyEnbN) |-> !$past(afSel));

  assert_enb_gap_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phyEnbN) |=> phyEnbN);

  assert_one_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fifoWrEn));

  assert_incr_on_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cellIncr != '0) |-> ((cellIncr & ~fifoWrEn) == '0) && $rose(phyEnbN));

  assert_perr_with_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (parityErr & ~fifoWrEn) == '0);
endmodule

bind cellRxPoller cellRxPollerChk #(.NUM_PHY(NUM_PHY)) chk_i (
  .clk(clk), .rstN(rstN), .phyAddr(phyAddr), .phyEnbN(phyEnbN),
  .phyClav(phyClav), .fifoAlmostFull(fifoAlmostFull),
  .fifoWrEn(fifoWrEn), .cellIncr(cellIncr), .parityErr(parityErr)
);

// File: tb/cellRxPoller_tb.sv
module cellRxPoller_tb_top;
  localparam int NPHY = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rstN;

  // 8-bit instance
  logic [4:0]        phyAddr;
  logic              phyEnbN, phyClav, phySoc, phyParity;
  logic [7:0]        phyData;
  logic [NPHY-1:0]   af;
  logic [NPHY*8-1:0] wrData;
  logic [NPHY-1:0]   wrEn, incr, perr;

  // 16-bit instance, two PHYs
  logic [4:0]  addr16;
  logic        enb16, clav16, soc16, par16;
  logic [15:0] data16;
  logic [31:0] wrData16;
  logic [1:0]  wrEn16, incr16, perr16;

  int checks = 0, errors = 0;
  int pending[NPHY];
  int pend16;
  int socAt = -1, corruptAt = -1;
  int w = 0, w16 = 0;

  cellRxPoller #(.NUM_PHY(NPHY), .DATA_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .phyAddr(phyAddr), .phyEnbN(phyEnbN),
    .phyClav(phyClav), .phySoc(phySoc), .phyData(phyData),
    .phyParity(phyParity), .fifoAlmostFull(af), .fifoWrData(wrData),
    .fifoWrEn(wrEn), .cellIncr(incr), .parityErr(perr));

  cellRxPoller #(.NUM_PHY(2), .DATA_W(16)) dut16_i (
    .clk(clk), .rstN(rstN), .phyAddr(addr16), .phyEnbN(enb16),
    .phyClav(clav16), .phySoc(soc16), .phyData(data16),
    .phyParity(par16), .fifoAlmostFull(2'b00), .fifoWrData(wrData16),
    .fifoWrEn(wrEn16), .cellIncr(incr16), .parityErr(perr16));

  assign phyClav = (phyAddr < 5'(NPHY)) && (pending[phyAddr[1:0]] > 0);
  assign clav16  = (addr16 == 5'd0) && (pend16 > 0);

  // PHY models: present a beat on every falling edge while enable is low
  always @(negedge clk) begin
    if (!phyEnbN) begin
      logic [7:0] d;
      if (w == 0) pending[phyAddr[1:0]] = pending[phyAddr[1:0]] - 1;
      d = 8'h30 + w[7:0];
      phyData   = d;
      phySoc    = (w == 0) || (w == socAt);
      phyParity = (~^d) ^ (w == corruptAt);
      w++;
    end else begin
      w = 0;
      phySoc = 1'b0;
    end
    if (!enb16) begin
      logic [15:0] d16;
      if (w16 == 0) pend16 = pend16 - 1;
      d16    = {8'h40 + w16[7:0], w16[7:0]};
      data16 = d16;
      soc16  = (w16 == 0);
      par16  = ~^d16;
      w16++;
    end else begin
      w16 = 0;
      soc16 = 1'b0;
    end
  end

  // monitors
  int writes[NPHY], incrs[NPHY], perrs[NPHY], sums[NPHY];
  int order[16];
  int nOrd = 0;
  int lowLen = 0, lastLowLen = 0, highLen = 0, minGap = 1000;
  logic addrMoved = 1'b0;
  logic [4:0] lowAddr = '0;
  int writes16 = 0, incrs16 = 0, lowLen16 = 0, lastLowLen16 = 0;
  logic [15:0] lastData16 = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!phyEnbN) begin
        if (lowLen == 0) begin
          lowAddr = phyAddr;
          if (highLen < minGap) minGap = highLen;
        end else if (phyAddr != lowAddr) addrMoved = 1'b1;
        lowLen++;
        highLen = 0;
      end else begin
        if (lowLen > 0) lastLowLen = lowLen;
        lowLen = 0;
        highLen++;
      end
      for (int p = 0; p < NPHY; p++) begin
        if (wrEn[p]) begin
          writes[p]++;
          sums[p] += int'(wrData[p*8 +: 8]);
        end
        if (incr[p]) begin
          incrs[p]++;
          if (nOrd < 16) order[nOrd] = p;
          nOrd++;
          check(wrEn[p], "R8", int'(wrEn[p]), 1);
        end
        if (perr[p]) perrs[p]++;
      end
      if (!enb16) lowLen16++;
      else begin
        if (lowLen16 > 0) lastLowLen16 = lowLen16;
        lowLen16 = 0;
      end
      if (wrEn16[0]) begin
        writes16++;
        lastData16 = wrData16[15:0];
      end
      if (incr16 != 2'b00) incrs16++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int totalIncr();
    int t = 0;
    for (int p = 0; p < NPHY; p++) t += incrs[p];
    return t;
  endfunction

  function automatic int expSum(input int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += int'(8'(8'h30 + i[7:0]));
    return s;
  endfunction

  task automatic clearStats();
    for (int p = 0; p < NPHY; p++) begin
      writes[p] = 0; incrs[p] = 0; perrs[p] = 0; sums[p] = 0;
    end
    nOrd = 0; addrMoved = 1'b0; minGap = 1000;
  endtask

  task automatic waitIncr(input int target, input string req);
    int n = 0;
    while (totalIncr() < target && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(totalIncr() >= target, req, totalIncr(), target);
    repeat (3) @(negedge clk);
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(phyEnbN == 1'b1, "R1 enable", int'(phyEnbN), 1);
    check(phyAddr == 5'd0, "R1 address", int'(phyAddr), 0);
    check((wrEn | incr | perr) == '0, "R1 strobes", int'(wrEn | incr | perr), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(phyEnbN == 1'b1 && wrEn == '0, "R1 release", int'(phyEnbN), 1);
  endtask

  task automatic tSingle();
    clearStats();
    pending[2] = 1;
    waitIncr(1, "R8 single cell");
    check(lowAddr == 5'd2 && !addrMoved, "R2 held address", int'(lowAddr), 2);
    check(lastLowLen == 53, "R5 enable length", lastLowLen, 53);
    check(writes[2] == 53, "R7 write count", writes[2], 53);
    check(sums[2] == expSum(53), "R7 data", sums[2], expSum(53));
    check(writes[0] + writes[1] + writes[3] == 0, "R7 other phys", writes[0] + writes[1] + writes[3], 0);
    check(incrs[2] == 1, "R8 one increment", incrs[2], 1);
    check(perrs[2] == 0, "R9 clean parity", perrs[2], 0);
  endtask

  task automatic tRoundRobin();
    clearStats();
    pending[0] = 2; pending[1] = 2; pending[3] = 2;
    waitIncr(6, "R4 six cells");
    for (int i = 1; i < 6; i++) begin
      int exp;
      exp = (order[i-1] == 0) ? 1 : (order[i-1] == 1) ? 3 : 0;
      check(order[i] == exp, "R4 order", order[i], exp);
    end
    check(minGap >= 1, "R5 gap between cells", minGap, 1);
    check(writes[0] == 106 && writes[1] == 106 && writes[3] == 106, "R7 per phy writes", writes[0], 106);
  endtask

  task automatic tAlmostFull();
    clearStats();
    af[1] = 1'b1;
    pending[1] = 1;
    repeat (400) @(negedge clk);
    check(writes[1] == 0 && phyEnbN, "R3 blocked while full", writes[1], 0);
    af[1] = 1'b0;
    waitIncr(1, "R3 served after clear");
    check(writes[1] == 53, "R3 cell after clear", writes[1], 53);
  endtask

  task automatic tParity();
    clearStats();
    corruptAt = 5;
    pending[0] = 1;
    waitIncr(1, "R9 cell");
    corruptAt = -1;
    check(perrs[0] == 1, "R9 error flagged", perrs[0], 1);
    check(perrs[1] + perrs[2] + perrs[3] == 0, "R9 other phys", perrs[1] + perrs[2] + perrs[3], 0);
  endtask

  task automatic tSoc();
    clearStats();
    socAt = 10;
    pending[3] = 1;
    waitIncr(1, "R10 cell");
    socAt = -1;
    check(lastLowLen == 63, "R10 enable length", lastLowLen, 63);
    check(writes[3] == 63, "R10 writes", writes[3], 63);
    check(incrs[3] == 1, "R10 one increment", incrs[3], 1);
  endtask

  task automatic tWide();
    int n = 0;
    pend16 = 1;
    while (incrs16 < 1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    check(incrs16 == 1, "R6 increment", incrs16, 1);
    check(lastLowLen16 == 27, "R6 enable length", lastLowLen16, 27);
    check(writes16 == 27, "R6 writes", writes16, 27);
    check(lastData16 == 16'h5A1A, "R6 upper byte", int'(lastData16), 16'h5A1A);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int p = 0; p < NPHY; p++) pending[p] = 0;
    pend16 = 0;
    af = '0;
    phyData = '0; phySoc = 1'b0; phyParity = 1'b1;
    data16 = '0; soc16 = 1'b0; par16 = 1'b1;
    tReset();
    tSingle();
    tRoundRobin();
    tAlmostFull();
    tParity();
    tSoc();
    tWide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule